// File: doc/BRIEF.md
# Set-Associative Translation Lookaside Buffer

This block caches translations from 4 KB virtual pages to physical frames for a paged 32-bit memory system. A lookup presents a linear address together with the access type (read or write, user or supervisor). One cycle later the block reports whether a usable translation was found, the physical address, and whether the access breaks the page's permissions. On a miss, an external page walker supplies a fill through a separate port. The fill carries the virtual page number, the frame number and three attribute bits.

Storage is 32 entries arranged as 8 sets of 4 ways. A linear address splits into a 12-bit page offset in bits 11:0, a set index in bits 14:12 and a 17-bit tag in bits 31:15. There is no per-entry invalidate. The array is emptied only as a side effect of reloading the page-directory base register. An explicit write to that register always flushes. A context-switch load flushes only when it brings a different base value.

Top module: `tlb_xlate`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and all response outputs and `dir_base_o` are zero.
- R2: A lookup presented with `lkp_valid_i` high is answered exactly one clock later with `rsp_valid_o` high. On a usable hit, `rsp_paddr_o` equals the stored 20-bit frame in bits 31:12 joined to the lookup's bits 11:0. In every other response `rsp_paddr_o` is zero, and with no lookup all response outputs are zero.
- R3: A fill (`fill_valid_i` high) writes an entry into set `fill_vpn_i[2:0]` with tag `fill_vpn_i[19:3]`, taking frame, present, writable and user bits from the fill. A fill whose set and tag match a valid entry overwrites that entry in place and adds no second copy.
- R4: A hit to a present entry faults (`rsp_hit_o`=1, `rsp_fault_o`=1, `rsp_paddr_o`=0) when a write (`lkp_write_i`=1) hits an entry whose writable bit is 0, or when a user access (`lkp_user_i`=1) hits an entry whose user bit is 0.
- R5: An entry stored with its present bit 0 never produces a hit. Its lookups report `rsp_hit_o`=0 and `rsp_fault_o`=0.
- R6: A fill that matches no entry goes to the lowest-numbered invalid way of its set, if any way is invalid.
- R7: With all 4 ways valid, the victim comes from a 3-bit tree per set. The root bit is 0 for the pair of ways 0/1 and 1 for the pair 2/3. The left bit is 0 for way 0 and 1 for way 1. The right bit is 0 for way 2 and 1 for way 3. A fault-free hit or a fill on a way points every bit on that way's path away from it. A fault-free hit is applied before a fill in the same cycle. The victim is chosen from the tree as it was before that cycle.
- R8: A cycle with `dir_wr_i` high invalidates all entries and clears all trees, even when `dir_val_i` equals the current base.
- R9: `dir_wr_i` or `ctx_sw_i` loads `dir_val_i` into the base register, which is seen on `dir_base_o` one cycle later. A `ctx_sw_i` load flushes only when `dir_val_i` differs from the current base. Otherwise all entries are kept.
- R10: A flush in the same cycle as a fill wins: the array ends with no valid entries.
- R11: A lookup in the same cycle as a fill or flush is answered from the array as it stood before that cycle's update.
- R12: Addresses that share a set index but differ in the tag never alias, and each of the 8 sets holds up to 4 translations independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vaddr_i | input | 32 | Linear address to translate |
| lkp_write_i | input | 1 | Access is a write |
| lkp_user_i | input | 1 | Access is from user mode |
| rsp_valid_o | output | 1 | Response for the previous cycle's lookup |
| rsp_hit_o | output | 1 | Present matching entry found |
| rsp_fault_o | output | 1 | Permission violation on the hit |
| rsp_paddr_o | output | 32 | Physical address, zero unless usable hit |
| fill_valid_i | input | 1 | Fill request from page walker |
| fill_vpn_i | input | 20 | Virtual page number being filled |
| fill_frame_i | input | 20 | Physical frame number |
| fill_present_i | input | 1 | Present attribute |
| fill_writable_i | input | 1 | Writable attribute |
| fill_user_i | input | 1 | User-accessible attribute |
| dir_wr_i | input | 1 | Explicit write of the directory base |
| ctx_sw_i | input | 1 | Context-switch load of the directory base |
| dir_val_i | input | 32 | New directory base value |
| dir_base_o | output | 32 | Current directory base |

## Verification
The hardest case to reach from the ports is a full set where the pseudo-LRU tree must pick a victim after a particular mix of hits and fills. Overlapping with that are fills, lookups and flushes that land in the same cycle. Directed steps fill all four ways of one set, touch chosen ways with hits, and then fill a fifth tag. Lookups then show which way was evicted. A long random phase keeps only six tags per set, so evictions, in-place refills, coincident lookups and fills, and occasional same-value and different-value base loads occur constantly. All of it is checked against a bench model of the array and trees.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned AW    = 32;
  localparam int unsigned PGW   = 12;
  localparam int unsigned SETS  = 8;
  localparam int unsigned WAYS  = 4;  // tree functions assume 4 ways
  localparam int unsigned IDXW  = $clog2(SETS);
  localparam int unsigned TAGW  = AW - PGW - IDXW;
  localparam int unsigned FRW   = AW - PGW;
  localparam int unsigned VPNW  = AW - PGW;
  localparam int unsigned LRUW  = WAYS - 1;
  localparam int unsigned WAYW  = $clog2(WAYS);
  localparam int unsigned NENT  = SETS * WAYS;

  typedef struct packed {
    logic [TAGW-1:0] tag;
    logic [FRW-1:0]  frame;
    logic            pres;
    logic            wr;
    logic            usr;
  } ent_t;

  function automatic logic [LRUW-1:0] lru_touch(logic [LRUW-1:0] s, logic [WAYW-1:0] w);
    logic [LRUW-1:0] n;
    n    = s;
    n[0] = ~w[1];
    if (!w[1]) n[1] = ~w[0];
    else       n[2] = ~w[0];
    return n;
  endfunction

  function automatic logic [WAYW-1:0] lru_victim(logic [LRUW-1:0] s);
    return s[0] ? {1'b1, s[2]} : {1'b0, s[1]};
  endfunction

  function automatic logic [WAYW-1:0] first_one(logic [WAYS-1:0] v);
    logic [WAYW-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = WAYW'(i);
    return r;
  endfunction
endpackage

// File: rtl/tlb_array.sv
module tlb_array
  import tlb_pkg::*;
(
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        flush_i,
  input  logic                        wr_en_i,
  input  logic [IDXW-1:0]             wr_set_i,
  input  logic [WAYW-1:0]             wr_way_i,
  input  ent_t                        wr_ent_i,
  input  logic [IDXW-1:0]             ra_set_i,
  output ent_t [WAYS-1:0]             ra_ent_o,
  output logic [WAYS-1:0]             ra_vld_o,
  input  logic [IDXW-1:0]             rb_set_i,
  output logic [WAYS-1:0][TAGW-1:0]   rb_tag_o,
  output logic [WAYS-1:0]             rb_vld_o,
  output logic [NENT-1:0]             vld_all_o
);
  ent_t [WAYS-1:0] ent_q [SETS];
  logic [WAYS-1:0] vld_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic sel;
    assign sel = wr_en_i && (wr_set_i == IDXW'(s));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      vld_q[s] <= '0;
      else if (flush_i) vld_q[s] <= '0;
      else if (sel)     vld_q[s][wr_way_i] <= 1'b1;
    end

    always_ff @(posedge clk_i) begin
      if (sel) ent_q[s][wr_way_i] <= wr_ent_i;
    end

    assign vld_all_o[s*WAYS +: WAYS] = vld_q[s];
  end

  assign ra_ent_o = ent_q[ra_set_i];
  assign ra_vld_o = vld_q[ra_set_i];
  assign rb_vld_o = vld_q[rb_set_i];

  always_comb begin
    for (int w = 0; w < WAYS; w++) rb_tag_o[w] = ent_q[rb_set_i][w].tag;
  end
endmodule

// File: rtl/tlb_plru.sv
module tlb_plru
  import tlb_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            flush_i,
  input  logic            t0_en_i,
  input  logic [IDXW-1:0] t0_set_i,
  input  logic [WAYW-1:0] t0_way_i,
  input  logic            t1_en_i,
  input  logic [IDXW-1:0] t1_set_i,
  input  logic [WAYW-1:0] t1_way_i,
  input  logic [IDXW-1:0] rd_set_i,
  input  logic [WAYS-1:0] rd_vld_i,
  output logic [WAYW-1:0] victim_o
);
  logic [LRUW-1:0] lru_q [SETS];

  for (genvar s = 0; s < SETS; s++) begin : g_set
    logic [LRUW-1:0] nxt;

    always_comb begin
      nxt = lru_q[s];
      if (t0_en_i && t0_set_i == IDXW'(s)) nxt = lru_touch(nxt, t0_way_i);
      if (t1_en_i && t1_set_i == IDXW'(s)) nxt = lru_touch(nxt, t1_way_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lru_q[s] <= '0;
      else if (flush_i) lru_q[s] <= '0;
      else              lru_q[s] <= nxt;
    end
  end

  // invalid way first, lowest index
  assign victim_o = (&rd_vld_i) ? lru_victim(lru_q[rd_set_i]) : first_one(~rd_vld_i);
endmodule

// File: rtl/tlb_match.sv
module tlb_match
  import tlb_pkg::*;
(
  input  logic [TAGW-1:0]           tag_i,
  input  logic [WAYS-1:0][TAGW-1:0] tags_i,
  input  logic [WAYS-1:0]           vld_i,
  output logic [WAYS-1:0]           match_o
);
  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign match_o[w] = vld_i[w] && (tags_i[w] == tag_i);
  end
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          lkp_valid_i,
  input  logic [AW-1:0] lkp_vaddr_i,
  input  logic          lkp_write_i,
  input  logic          lkp_user_i,
  output logic          rsp_valid_o,
  output logic          rsp_hit_o,
  output logic          rsp_fault_o,
  output logic [AW-1:0] rsp_paddr_o,
  input  logic          fill_valid_i,
  input  logic [VPNW-1:0] fill_vpn_i,
  input  logic [FRW-1:0]  fill_frame_i,
  input  logic          fill_present_i,
  input  logic          fill_writable_i,
  input  logic          fill_user_i,
  input  logic          dir_wr_i,
  input  logic          ctx_sw_i,
  input  logic [AW-1:0] dir_val_i,
  output logic [AW-1:0] dir_base_o
);
  logic [AW-1:0] dir_base_q;
  logic          flush;

  assign flush = dir_wr_i || (ctx_sw_i && (dir_val_i != dir_base_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   dir_base_q <= '0;
    else if (dir_wr_i || ctx_sw_i) dir_base_q <= dir_val_i;
  end
  assign dir_base_o = dir_base_q;

  // lookup side
  logic [IDXW-1:0]           lk_set;
  logic [TAGW-1:0]           lk_tag;
  ent_t [WAYS-1:0]           lk_ents;
  logic [WAYS-1:0]           lk_vld, lk_match, lk_pres, lk_hitv;
  logic [WAYS-1:0][TAGW-1:0] lk_tags;
  logic [WAYW-1:0]           lk_way;
  logic                      lk_hit, lk_fault, lk_ok;
  logic [FRW-1:0]            lk_frame;

  assign lk_set = lkp_vaddr_i[PGW +: IDXW];
  assign lk_tag = lkp_vaddr_i[AW-1 -: TAGW];

  always_comb begin
    for (int w = 0; w < WAYS; w++) begin
      lk_tags[w] = lk_ents[w].tag;
      lk_pres[w] = lk_ents[w].pres;
    end
  end

  // fill side
  logic [IDXW-1:0]           fl_set;
  logic [TAGW-1:0]           fl_tag;
  logic [WAYS-1:0][TAGW-1:0] fl_tags;
  logic [WAYS-1:0]           fl_vld, fl_match;
  logic [WAYW-1:0]           fl_victim, fl_way;
  logic                      fl_en;
  ent_t                      fl_ent;
  logic [NENT-1:0]           vld_all;

  assign fl_set = fill_vpn_i[IDXW-1:0];
  assign fl_tag = fill_vpn_i[VPNW-1 -: TAGW];
  assign fl_en  = fill_valid_i && !flush;
  assign fl_way = (|fl_match) ? first_one(fl_match) : fl_victim;

  always_comb begin
    fl_ent.tag   = fl_tag;
    fl_ent.frame = fill_frame_i;
    fl_ent.pres  = fill_present_i;
    fl_ent.wr    = fill_writable_i;
    fl_ent.usr   = fill_user_i;
  end

  tlb_array u_array (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (flush),
    .wr_en_i   (fl_en),
    .wr_set_i  (fl_set),
    .wr_way_i  (fl_way),
    .wr_ent_i  (fl_ent),
    .ra_set_i  (lk_set),
    .ra_ent_o  (lk_ents),
    .ra_vld_o  (lk_vld),
    .rb_set_i  (fl_set),
    .rb_tag_o  (fl_tags),
    .rb_vld_o  (fl_vld),
    .vld_all_o (vld_all)
  );

  tlb_match u_lk_match (
    .tag_i   (lk_tag),
    .tags_i  (lk_tags),
    .vld_i   (lk_vld),
    .match_o (lk_match)
  );

  tlb_match u_fl_match (
    .tag_i   (fl_tag),
    .tags_i  (fl_tags),
    .vld_i   (fl_vld),
    .match_o (fl_match)
  );

  assign lk_hitv  = lk_match & lk_pres;
  assign lk_hit   = |lk_hitv;
  assign lk_way   = first_one(lk_hitv);
  assign lk_frame = lk_ents[lk_way].frame;
  assign lk_fault = lk_hit && ((lkp_write_i && !lk_ents[lk_way].wr) ||
                               (lkp_user_i  && !lk_ents[lk_way].usr));
  assign lk_ok    = lkp_valid_i && lk_hit && !lk_fault;

  tlb_plru u_plru (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .flush_i  (flush),
    .t0_en_i  (lk_ok),
    .t0_set_i (lk_set),
    .t0_way_i (lk_way),
    .t1_en_i  (fl_en),
    .t1_set_i (fl_set),
    .t1_way_i (fl_way),
    .rd_set_i (fl_set),
    .rd_vld_i (fl_vld),
    .victim_o (fl_victim)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_fault_o <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= lkp_valid_i;
      rsp_hit_o   <= lkp_valid_i && lk_hit;
      rsp_fault_o <= lkp_valid_i && lk_fault;
      rsp_paddr_o <= lk_ok ? {lk_frame, lkp_vaddr_i[PGW-1:0]} : '0;
    end
  end
endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk
  import tlb_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           lkp_valid_i,
  input logic [PGW-1:0] lkp_off_i,
  input logic           rsp_valid_o,
  input logic           rsp_hit_o,
  input logic           rsp_fault_o,
  input logic [AW-1:0]  rsp_paddr_o,
  input logic           fill_valid_i,
  input logic           dir_wr_i,
  input logic           ctx_sw_i,
  input logic [AW-1:0]  dir_val_i,
  input logic [AW-1:0]  dir_base_o,
  input logic [NENT-1:0] vld_all
);
  // R2
  rsp_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> rsp_valid_o);

  // R2
  rsp_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lkp_valid_i |=> (!rsp_valid_o && !rsp_hit_o && !rsp_fault_o && rsp_paddr_o == '0));

  // R2
  offset_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lkp_valid_i |=> (!(rsp_hit_o && !rsp_fault_o) || rsp_paddr_o[PGW-1:0] == $past(lkp_off_i)));

  // R4
  fault_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault_o |-> (rsp_hit_o && rsp_paddr_o == '0));

  // R8
  wr_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dir_wr_i |=> vld_all == '0);

  // R9
  same_base_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctx_sw_i && !dir_wr_i && !fill_valid_i && dir_val_i == dir_base_o) |=> $stable(vld_all));

  // R9
  base_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_wr_i || ctx_sw_i) |=> dir_base_o == $past(dir_val_i));

  // R3
  fill_grow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && !dir_wr_i && !ctx_sw_i) |=>
      (vld_all != '0 && $countones(vld_all) <= $past($countones(vld_all)) + 1));

  // R1
  reset_state_chk: assert property (@(posedge clk_i) !rst_ni |-> (!rsp_valid_o && vld_all == '0));
endmodule

bind tlb_xlate tlb_xlate_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .lkp_valid_i  (lkp_valid_i),
  .lkp_off_i    (lkp_vaddr_i[11:0]),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_hit_o    (rsp_hit_o),
  .rsp_fault_o  (rsp_fault_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .fill_valid_i (fill_valid_i),
  .dir_wr_i     (dir_wr_i),
  .ctx_sw_i     (ctx_sw_i),
  .dir_val_i    (dir_val_i),
  .dir_base_o   (dir_base_o),
  .vld_all      (vld_all)
);

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        lkp_valid = 0, lkp_write = 0, lkp_user = 0;
  logic [31:0] lkp_vaddr = '0;
  logic        rsp_valid, rsp_hit, rsp_fault;
  logic [31:0] rsp_paddr, dir_base;
  logic        fill_valid = 0, fill_p = 0, fill_w = 0, fill_u = 0;
  logic [19:0] fill_vpn = '0, fill_frame = '0;
  logic        dir_wr = 0, ctx_sw = 0;
  logic [31:0] dir_val = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tlb_xlate uut (
    .clk_i(clk), .rst_ni(rst_n),
    .lkp_valid_i(lkp_valid), .lkp_vaddr_i(lkp_vaddr), .lkp_write_i(lkp_write), .lkp_user_i(lkp_user),
    .rsp_valid_o(rsp_valid), .rsp_hit_o(rsp_hit), .rsp_fault_o(rsp_fault), .rsp_paddr_o(rsp_paddr),
    .fill_valid_i(fill_valid), .fill_vpn_i(fill_vpn), .fill_frame_i(fill_frame),
    .fill_present_i(fill_p), .fill_writable_i(fill_w), .fill_user_i(fill_u),
    .dir_wr_i(dir_wr), .ctx_sw_i(ctx_sw), .dir_val_i(dir_val), .dir_base_o(dir_base)
  );

  // reference model
  bit          m_vld [8][4];
  logic [16:0] m_tag [8][4];
  logic [19:0] m_fr  [8][4];
  bit          m_p [8][4], m_w [8][4], m_u [8][4];
  bit   [2:0]  m_lru [8];
  logic [31:0] m_base;

  function automatic logic [31:0] va(int tag, int set, int off);
    return {tag[16:0], set[2:0], off[11:0]};
  endfunction

  function automatic bit [2:0] tree_use(bit [2:0] s, int w);
    bit [2:0] n = s;
    if (w < 2) begin n[0] = 1; n[1] = (w == 0); end
    else       begin n[0] = 0; n[2] = (w == 2); end
    return n;
  endfunction

  function automatic int tree_pick(bit [2:0] s);
    if (s[0] == 0) return s[1] ? 1 : 0;
    return s[2] ? 3 : 2;
  endfunction

  task automatic model_clear();
    for (int s = 0; s < 8; s++) begin
      m_lru[s] = 0;
      for (int w = 0; w < 4; w++) m_vld[s][w] = 0;
    end
  endtask

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one clock: drive at negedge, predict, advance to next negedge, check
  task automatic cyc(bit lv, logic [31:0] la, bit lw, bit lu,
                     bit fv, logic [19:0] fvpn, logic [19:0] ffr, bit fp, bit fw, bit fu,
                     bit dw, bit cs, logic [31:0] dv, string req);
    int set, hw, fs, fw_i, hitw;
    bit e_hit, e_fault, flush;
    logic [31:0] e_pa;
    lkp_valid = lv; lkp_vaddr = la; lkp_write = lw; lkp_user = lu;
    fill_valid = fv; fill_vpn = fvpn; fill_frame = ffr; fill_p = fp; fill_w = fw; fill_u = fu;
    dir_wr = dw; ctx_sw = cs; dir_val = dv;

    set = int'(la[14:12]);
    e_hit = 0; hw = 0;
    for (int w = 3; w >= 0; w--)
      if (m_vld[set][w] && m_tag[set][w] == la[31:15] && m_p[set][w]) begin e_hit = 1; hw = w; end
    e_fault = e_hit && ((lw && !m_w[set][hw]) || (lu && !m_u[set][hw]));
    e_pa = (e_hit && !e_fault) ? {m_fr[set][hw], la[11:0]} : 32'h0;

    flush = dw || (cs && dv != m_base);
    fs = int'(fvpn[2:0]);
    hitw = -1;
    for (int w = 3; w >= 0; w--)
      if (m_vld[fs][w] && m_tag[fs][w] == fvpn[19:3]) hitw = w;
    if (hitw >= 0) fw_i = hitw;
    else begin
      fw_i = -1;
      for (int w = 3; w >= 0; w--) if (!m_vld[fs][w]) fw_i = w;
      if (fw_i < 0) fw_i = tree_pick(m_lru[fs]);
    end

    if (flush) model_clear();
    else begin
      if (lv && e_hit && !e_fault) m_lru[set] = tree_use(m_lru[set], hw);
      if (fv) begin
        m_vld[fs][fw_i] = 1; m_tag[fs][fw_i] = fvpn[19:3]; m_fr[fs][fw_i] = ffr;
        m_p[fs][fw_i] = fp; m_w[fs][fw_i] = fw; m_u[fs][fw_i] = fu;
        m_lru[fs] = tree_use(m_lru[fs], fw_i);
      end
    end
    if (dw || cs) m_base = dv;

    @(negedge clk);
    chk(req, {31'b0, rsp_valid}, {31'b0, lv}, "rsp_valid");
    chk(req, {31'b0, rsp_hit},   {31'b0, lv && e_hit}, "rsp_hit");
    chk(req, {31'b0, rsp_fault}, {31'b0, lv && e_fault}, "rsp_fault");
    chk(req, rsp_paddr, lv ? e_pa : 32'h0, "rsp_paddr");
    chk("R9", dir_base, m_base, "dir_base");
  endtask

  task automatic look(logic [31:0] a, bit w, bit u, string req);
    cyc(1, a, w, u, 0, '0, '0, 0, 0, 0, 0, 0, '0, req);
  endtask

  task automatic fill(int tag, int set, logic [19:0] fr, bit p, bit w, bit u, string req);
    cyc(0, '0, 0, 0, 1, {tag[16:0], set[2:0]}, fr, p, w, u, 0, 0, '0, req);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20251));
    model_clear();
    m_base = '0;
    repeat (3) @(negedge clk);
    // R1 outputs during reset
    chk("R1", {rsp_valid, rsp_hit, rsp_fault}, 3'b000, "reset flags");
    chk("R1", rsp_paddr, 32'h0, "reset paddr");
    chk("R1", dir_base, 32'h0, "reset base");
    rst_n = 1'b1;
    @(negedge clk);

    look(va(5, 1, 'h123), 0, 0, "R1");
    // R2 R3 basic fill and translate
    fill(5, 1, 20'hABCDE, 1, 1, 1, "R3");
    look(va(5, 1, 'h123), 0, 0, "R2");
    chk("R2", rsp_paddr, 32'hABCDE123, "direct paddr");
    // R12 same set other tag, other set same tag
    look(va(6, 1, 'h10), 0, 0, "R12");
    look(va(5, 2, 'h10), 0, 0, "R12");
    // R4 permissions
    fill(9, 3, 20'h11111, 1, 0, 0, "R4");
    look(va(9, 3, 'h4), 1, 0, "R4");
    chk("R4", {31'b0, rsp_fault}, 32'h1, "write to ro");
    look(va(9, 3, 'h4), 0, 1, "R4");
    look(va(9, 3, 'h4), 0, 0, "R4");
    chk("R4", rsp_paddr, 32'h11111004, "supervisor read");
    // R5 not present
    fill(7, 4, 20'h22222, 0, 1, 1, "R5");
    look(va(7, 4, 'h0), 0, 0, "R5");
    chk("R5", {30'b0, rsp_hit, rsp_fault}, 32'h0, "absent miss");
    // R6 R7 fill a full set, touch, evict
    for (int t = 0; t < 4; t++) fill(20 + t, 2, 20'h30000 + 20'(t), 1, 1, 1, "R6");
    look(va(20, 2, 0), 0, 0, "R7");
    look(va(22, 2, 0), 0, 0, "R7");
    fill(30, 2, 20'h3FFFF, 1, 1, 1, "R7");
    for (int t = 0; t < 4; t++) look(va(20 + t, 2, 'h8), 0, 0, "R7");
    look(va(30, 2, 'h8), 0, 0, "R7");
    // R3 in-place refill
    fill(5, 1, 20'h55555, 1, 1, 1, "R3");
    look(va(5, 1, 'h1), 0, 0, "R3");
    chk("R3", rsp_paddr, 32'h55555001, "refill frame");
    // R11 lookup and fill together
    cyc(1, va(40, 5, 'h2), 0, 0, 1, {17'd40, 3'd5}, 20'h77777, 1, 1, 1, 0, 0, '0, "R11");
    look(va(40, 5, 'h2), 0, 0, "R11");
    // R9 same-value context switch keeps entries, then new value flushes
    cyc(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 0, 1, 32'h0, "R9");
    look(va(5, 1, 'h3), 0, 0, "R9");
    cyc(0, '0, 0, 0, 0, '0, '0, 0, 0, 0, 0, 1, 32'h1000, "R9");
    look(va(5, 1, 'h3), 0, 0, "R9");
    // R8 explicit write with same value still flushes
    fill(5, 1, 20'h12345, 1, 1, 1, "R8");
    cyc(1, va(5, 1, 'h3), 0, 0, 0, '0, '0, 0, 0, 0, 1, 0, 32'h1000, "R11");
    look(va(5, 1, 'h3), 0, 0, "R8");
    // R10 flush beats fill
    cyc(0, '0, 0, 0, 1, {17'd8, 3'd6}, 20'h88888, 1, 1, 1, 1, 0, 32'h2000, "R10");
    look(va(8, 6, 'h0), 0, 0, "R10");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      int r = int'($urandom_range(0, 99));
      bit lv = ($urandom_range(0, 9) < 7);
      bit fv = ($urandom_range(0, 9) < 4);
      bit dw = (r == 0);
      bit cs = (r == 1 || r == 2);
      logic [31:0] dv = (($urandom_range(0, 1) == 1) ? 32'h2000 : 32'h3000);
      int lt = int'($urandom_range(0, 5)), ls = int'($urandom_range(0, 7));
      int ft = int'($urandom_range(0, 5)), fs = int'($urandom_range(0, 7));
      cyc(lv, va(lt, ls, int'($urandom_range(0, 4095))), 1'($urandom), 1'($urandom),
          fv, {ft[16:0], fs[2:0]}, 20'($urandom), ($urandom_range(0, 7) != 0),
          1'($urandom), 1'($urandom), dw, cs, dv, "R7 R12");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule